// File: doc/BRIEF.md
# Nibble ALU with Condition Flags

This block is the arithmetic and logic stage of a small 4-bit processor datapath. It combines the accumulator nibble (`tos_in`) with a second operand nibble (`nos_in`) according to a 5-bit operation code. It returns the 4-bit result combinationally in the same cycle. A 4-bit condition register holds carry/borrow, branch and interrupt-enable state. When `op_valid` is high, that register is written on the rising clock edge.

Arithmetic operations record carry or borrow. Shifts and rotates use the carry as a fifth data bit. Logic operations leave carry alone but still refresh the branch flag. Four flag operations act on the register directly: set branch and carry together, toggle branch, load the whole register from a nibble, and disable interrupts. A sequencer raises `jump_req` for a conditional jump and reads back `br_taken` to learn whether the jump is taken.

Condition register layout:

| Bit | Meaning |
|-----|---------|
| 0 | carry |
| 1 | branch |
| 2 | reserved, always 0 |
| 3 | interrupt enable |

Top module: `nib_alu_unit`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high at a rising edge, the condition register (`ccr_out`) becomes 4'h0; in particular, interrupt enable (bit 3) is cleared. The register layout is carry in bit 0, branch in bit 1, reserved zero in bit 2, interrupt enable in bit 3.
- R2: Add operations. Opcode 1 computes tos+nos. Opcode 2 computes tos+nos+carry. The result is the low 4 bits of the sum. Carry takes the carry out of bit 3, and branch takes the same value as the new carry.
- R3: Subtract operations. Opcode 3 computes tos-nos. Opcode 4 computes tos-nos-carry. The result wraps modulo 16. Carry takes the borrow, which is 1 when the true difference is negative, and branch takes the same value as the new carry.
- R4: Increment and decrement. Opcode 5 computes tos+1, and carry is the carry out. Opcode 6 computes tos-1, and carry is the borrow, which is 1 only when tos is 0. In both cases branch takes the same value as the new carry.
- R5: Logic operations are AND (opcode 7), OR (opcode 8), XOR (opcode 9) and NOT of tos (opcode 10). They leave carry unchanged. Branch is set to 1 exactly when the 4-bit result is zero.
- R6: Plain shifts. Opcode 11 shifts tos left and fills bit 0 with 0; bit 3 of tos moves into carry. Opcode 12 shifts tos right and fills bit 3 with 0; bit 0 of tos moves into carry. Branch is set to 1 exactly when the result is zero.
- R7: Rotates through carry. Opcode 13 rotates left, so the old carry enters bit 0 and bit 3 of tos leaves into carry. Opcode 14 rotates right, so the old carry enters bit 3 and bit 0 of tos leaves into carry. Branch is set to 1 exactly when the result is zero.
- R8: Opcode 16 sets both branch and carry to 1 and leaves interrupt enable unchanged.
- R9: Opcode 17 inverts branch and leaves carry and interrupt enable unchanged.
- R10: Opcode 18 loads the condition register from `tos_in`, except that bit 2 is always written as 0.
- R11: Opcode 19 clears interrupt enable and leaves carry and branch unchanged.
- R12: While `op_valid` is low, the condition register holds its value whatever the opcode is.
- R13: `br_taken` is high exactly when `jump_req` is high and the branch flag (bit 1) is set.
- R14: The result equals `tos_in` for opcode 0 (no operation) and for opcodes 16 to 19. Opcodes 15 and 20 to 31 are undefined: they give result 0 and leave the condition register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit the flag update of `op_code` at the next edge |
| op_code | input | 5 | Operation selector |
| tos_in | input | 4 | Accumulator operand |
| nos_in | input | 4 | Second operand |
| jump_req | input | 1 | A conditional jump is pending |
| result | output | 4 | Combinational operation result |
| ccr_out | output | 4 | Condition register contents |
| br_taken | output | 1 | Pending conditional jump is taken |

## Verification
Several corner cases are targeted because a plausible mistake in each would show up as a wrong flag.

- **Carry wrap:** the bench drives values such as F+1 and 7+9, where the 4-bit result wraps to zero. An adder that drops its fifth bit would show carry 0 here.
- **Borrow chains:** it drives 0-1 and 5-5 with an incoming borrow. A design that inverted the borrow sense would report 0 on exactly these underflows.
- **Logic and carry:** logic operations are run with carry preset to 1. A design that cleared carry on logic operations would show carry 0 afterwards.
- **Rotate fill:** rotates are run with carry both set and clear, so a rotate wired as a plain shift fills the vacated bit wrongly.
- **Flag operations:** these are checked for disturbing neighbouring bits, for example interrupt enable lost on set-branch-and-carry, or reserved bit 2 written from a load.
- **Idle and undefined opcodes:** these are checked for leaking a flag update.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    localparam int NIB_W = 4;
    localparam int OP_W  = 5;
    localparam int CCR_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADDC  = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBB  = 5'd4,
        OP_INC   = 5'd5,
        OP_DEC   = 5'd6,
        OP_AND   = 5'd7,
        OP_OR    = 5'd8,
        OP_XOR   = 5'd9,
        OP_NOT   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_ROL   = 5'd13,
        OP_ROR   = 5'd14,
        OP_SETBC = 5'd16,
        OP_TOGB  = 5'd17,
        OP_LDCCR = 5'd18,
        OP_DISI  = 5'd19
    } nib_op_e;

    typedef enum logic [2:0] {
        CLS_PASS,
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_FLAG,
        CLS_BAD
    } op_cls_e;

    // Condition register: ie bit 3, reserved bit 2, branch bit 1, carry bit 0
    typedef struct packed {
        logic ie;
        logic rsvd;
        logic br;
        logic cy;
    } ccr_t;

    function automatic op_cls_e classify(input logic [OP_W-1:0] code);
        op_cls_e cls;
        case (code)
            OP_NOP:                                      cls = CLS_PASS;
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
            OP_INC, OP_DEC:                              cls = CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:               cls = CLS_LOGIC;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR:              cls = CLS_SHIFT;
            OP_SETBC, OP_TOGB, OP_LDCCR, OP_DISI:        cls = CLS_FLAG;
            default:                                     cls = CLS_BAD;
        endcase
        return cls;
    endfunction

    function automatic logic nib_zero(input logic [NIB_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/nib_arith.sv
module nib_arith
    import nib_alu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] ea, eb, ec, one, ext;

    assign ea  = {1'b0, a};
    assign eb  = {1'b0, b};
    assign ec  = {{W{1'b0}}, cin};
    assign one = EXT_W'(1);

    // For subtraction the wrap of the extended word puts the borrow in bit W
    always_comb begin
        case (op)
            OP_ADD:  ext = ea + eb;
            OP_ADDC: ext = ea + eb + ec;
            OP_SUB:  ext = ea - eb;
            OP_SUBB: ext = ea - eb - ec;
            OP_INC:  ext = ea + one;
            OP_DEC:  ext = ea - one;
            default: ext = '0;
        endcase
    end

    assign res  = ext[W-1:0];
    assign cout = ext[W];

endmodule

// File: rtl/nib_logic.sv
module nib_logic
    import nib_alu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/nib_shift.sv
module nib_shift
    import nib_alu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    logic fill_lo, fill_hi;

    // Rotates feed the old carry into the vacated bit, shifts feed zero
    assign fill_lo = (op == OP_ROL) ? cin : 1'b0;
    assign fill_hi = (op == OP_ROR) ? cin : 1'b0;

    always_comb begin
        case (op)
            OP_SHL, OP_ROL: begin
                res  = {a[W-2:0], fill_lo};
                cout = a[W-1];
            end
            OP_SHR, OP_ROR: begin
                res  = {fill_hi, a[W-1:1]};
                cout = a[0];
            end
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nib_ccr.sv
module nib_ccr
    import nib_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic [OP_W-1:0] op,
    input  logic            new_cy,
    input  logic            res_zero,
    input  logic [CCR_W-1:0] load_val,
    output ccr_t            ccr_q
);
    op_cls_e cls;
    ccr_t    ccr_d;

    assign cls = classify(op);

    always_comb begin
        ccr_d = ccr_q;
        case (cls)
            CLS_ARITH: begin
                ccr_d.cy = new_cy;
                ccr_d.br = new_cy;
            end
            CLS_LOGIC: begin
                ccr_d.br = res_zero;
            end
            CLS_SHIFT: begin
                ccr_d.cy = new_cy;
                ccr_d.br = res_zero;
            end
            CLS_FLAG: begin
                case (op)
                    OP_SETBC: begin
                        ccr_d.cy = 1'b1;
                        ccr_d.br = 1'b1;
                    end
                    OP_TOGB:  ccr_d.br = ~ccr_q.br;
                    OP_LDCCR: ccr_d = ccr_t'(load_val);
                    OP_DISI:  ccr_d.ie = 1'b0;
                    default:  ccr_d = ccr_q;
                endcase
            end
            default: ccr_d = ccr_q;
        endcase
        ccr_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ccr_q <= '0;
        else if (upd) ccr_q <= ccr_d;
    end

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ccr_q));

    assert_arith_br_cy_R2: assert property (@(posedge clk) disable iff (rst)
        (upd && classify(op) == CLS_ARITH) |=> (ccr_q.br == ccr_q.cy));

    assert_logic_keep_cy_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && classify(op) == CLS_LOGIC) |=> $stable(ccr_q.cy));

    assert_setbc_R8: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_SETBC) |=> (ccr_q.cy && ccr_q.br && $stable(ccr_q.ie)));

    assert_togb_R9: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_TOGB) |=> (ccr_q.br != $past(ccr_q.br) && $stable(ccr_q.cy)));

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_LDCCR) |=> !ccr_q.rsvd);

    assert_disi_R11: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_DISI) |=> (!ccr_q.ie && $stable(ccr_q.cy) && $stable(ccr_q.br)));

    assert_bad_op_R14: assert property (@(posedge clk) disable iff (rst)
        (upd && classify(op) == CLS_BAD) |=> $stable(ccr_q));

endmodule

// File: rtl/nib_alu_unit.sv
module nib_alu_unit
    import nib_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic [NIB_W-1:0] tos_in,
    input  logic [NIB_W-1:0] nos_in,
    input  logic             jump_req,
    output logic [NIB_W-1:0] result,
    output logic [CCR_W-1:0] ccr_out,
    output logic             br_taken
);
    op_cls_e          cls;
    ccr_t             ccr_q;
    logic [NIB_W-1:0] ar_res, lg_res, sh_res;
    logic             ar_cy, sh_cy, cy_sel;

    assign cls = classify(op_code);

    nib_arith #(.W(NIB_W)) u_arith (
        .op   (op_code),
        .a    (tos_in),
        .b    (nos_in),
        .cin  (ccr_q.cy),
        .res  (ar_res),
        .cout (ar_cy)
    );

    nib_logic #(.W(NIB_W)) u_logic (
        .op  (op_code),
        .a   (tos_in),
        .b   (nos_in),
        .res (lg_res)
    );

    nib_shift #(.W(NIB_W)) u_shift (
        .op   (op_code),
        .a    (tos_in),
        .cin  (ccr_q.cy),
        .res  (sh_res),
        .cout (sh_cy)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: result = ar_res;
            CLS_LOGIC: result = lg_res;
            CLS_SHIFT: result = sh_res;
            CLS_PASS,
            CLS_FLAG:  result = tos_in;
            default:   result = '0;
        endcase
    end

    assign cy_sel = (cls == CLS_SHIFT) ? sh_cy : ar_cy;

    nib_ccr u_ccr (
        .clk      (clk),
        .rst      (rst),
        .upd      (op_valid),
        .op       (op_code),
        .new_cy   (cy_sel),
        .res_zero (nib_zero(result)),
        .load_val (tos_in),
        .ccr_q    (ccr_q)
    );

    assign ccr_out  = ccr_q;
    assign br_taken = jump_req & ccr_q.br;

    assert_logic_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cls == CLS_LOGIC) |=> (ccr_out[1] == ($past(result) == '0)));

    assert_shift_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && cls == CLS_SHIFT) |=> (ccr_out[1] == ($past(result) == '0)));

endmodule

// File: tb/nib_alu_unit_bench.sv
`timescale 1ns/1ps
module nib_alu_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [4:0] op_code;
    logic [3:0] tos_in, nos_in;
    logic       jump_req;
    logic [3:0] result, ccr_out;
    logic       br_taken;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nib_alu_unit u_nib_alu_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .tos_in(tos_in), .nos_in(nos_in), .jump_req(jump_req),
        .result(result), .ccr_out(ccr_out), .br_taken(br_taken)
    );

    // {op, tos, nos, ccr before, expected result, expected ccr, requirement}
    localparam int NV = 34;
    localparam logic [28:0] VEC [NV] = '{
        {5'd1,  4'h7, 4'h9, 4'h8, 4'h0, 4'hB, 4'd2},  // R2 add wraps, ie kept
        {5'd1,  4'h3, 4'h4, 4'h3, 4'h7, 4'h0, 4'd2},  // R2
        {5'd2,  4'h7, 4'h8, 4'h1, 4'h0, 4'h3, 4'd2},  // R2 add with carry
        {5'd2,  4'h5, 4'h2, 4'h0, 4'h7, 4'h0, 4'd2},  // R2
        {5'd3,  4'h3, 4'h5, 4'h0, 4'hE, 4'h3, 4'd3},  // R3 borrow
        {5'd3,  4'h9, 4'h4, 4'h3, 4'h5, 4'h0, 4'd3},  // R3
        {5'd4,  4'h5, 4'h5, 4'h1, 4'hF, 4'h3, 4'd3},  // R3 borrow chain
        {5'd4,  4'h6, 4'h2, 4'h9, 4'h3, 4'h8, 4'd3},  // R3
        {5'd5,  4'hF, 4'h0, 4'h0, 4'h0, 4'h3, 4'd4},  // R4 inc wraps
        {5'd5,  4'h6, 4'h0, 4'h3, 4'h7, 4'h0, 4'd4},  // R4
        {5'd6,  4'h0, 4'h0, 4'h0, 4'hF, 4'h3, 4'd4},  // R4 dec underflow
        {5'd6,  4'h8, 4'h0, 4'h0, 4'h7, 4'h0, 4'd4},  // R4
        {5'd7,  4'hC, 4'hA, 4'h1, 4'h8, 4'h1, 4'd5},  // R5 carry kept
        {5'd7,  4'h5, 4'hA, 4'h0, 4'h0, 4'h2, 4'd5},  // R5 zero -> branch
        {5'd8,  4'h0, 4'h0, 4'h9, 4'h0, 4'hB, 4'd5},  // R5
        {5'd9,  4'h6, 4'h3, 4'h2, 4'h5, 4'h0, 4'd5},  // R5
        {5'd10, 4'hF, 4'h0, 4'h1, 4'h0, 4'h3, 4'd5},  // R5
        {5'd11, 4'h9, 4'h0, 4'h0, 4'h2, 4'h1, 4'd6},  // R6
        {5'd11, 4'h8, 4'h0, 4'h0, 4'h0, 4'h3, 4'd6},  // R6
        {5'd12, 4'h3, 4'h0, 4'h2, 4'h1, 4'h1, 4'd6},  // R6
        {5'd12, 4'h1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd6},  // R6
        {5'd13, 4'h4, 4'h0, 4'h1, 4'h9, 4'h0, 4'd7},  // R7 carry enters bit 0
        {5'd13, 4'h8, 4'h0, 4'h0, 4'h0, 4'h3, 4'd7},  // R7
        {5'd14, 4'h2, 4'h0, 4'h1, 4'h9, 4'h0, 4'd7},  // R7 carry enters bit 3
        {5'd14, 4'h1, 4'h0, 4'h0, 4'h0, 4'h3, 4'd7},  // R7
        {5'd16, 4'h5, 4'h0, 4'h8, 4'h5, 4'hB, 4'd8},  // R8
        {5'd17, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'd9},  // R9
        {5'd17, 4'h0, 4'h0, 4'h9, 4'h0, 4'hB, 4'd9},  // R9
        {5'd18, 4'hF, 4'h0, 4'h0, 4'hF, 4'hB, 4'd10}, // R10 bit 2 dropped
        {5'd18, 4'h4, 4'h0, 4'hB, 4'h4, 4'h0, 4'd10}, // R10
        {5'd19, 4'h6, 4'h0, 4'hB, 4'h6, 4'h3, 4'd11}, // R11
        {5'd0,  4'h7, 4'h0, 4'hB, 4'h7, 4'hB, 4'd14}, // R14 nop passes tos
        {5'd15, 4'h7, 4'h1, 4'hB, 4'h0, 4'hB, 4'd14}, // R14 undefined
        {5'd25, 4'h3, 4'h2, 4'h9, 4'h0, 4'h9, 4'd14}  // R14 undefined
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_ccr(input logic [3:0] v);
        @(negedge clk);
        op_valid = 1'b1; op_code = 5'd18; tos_in = v; nos_in = 4'h0;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; tos_in = '0; nos_in = '0; jump_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset ccr", ccr_out, 4'h0);
        check("R1 reset br_taken", {3'b0, br_taken}, 4'h0);

        for (int i = 0; i < NV; i++) begin
            logic [4:0] v_op;
            logic [3:0] v_tos, v_nos, v_pre, v_res, v_ccr, v_req;
            {v_op, v_tos, v_nos, v_pre, v_res, v_ccr, v_req} = VEC[i];
            load_ccr(v_pre);
            op_valid = 1'b1; op_code = v_op; tos_in = v_tos; nos_in = v_nos;
            #2;
            check($sformatf("R%0d vec %0d result", v_req, i), result, v_res);
            @(negedge clk);
            op_valid = 1'b0;
            check($sformatf("R%0d vec %0d ccr", v_req, i), ccr_out, v_ccr);
        end

        // R12: op_valid low, flags must hold
        load_ccr(4'hB);
        op_valid = 1'b0; op_code = 5'd1; tos_in = 4'h1; nos_in = 4'h2;
        @(negedge clk);
        op_code = 5'd19;
        @(negedge clk);
        check("R12 idle hold", ccr_out, 4'hB);

        // R13: conditional branch
        jump_req = 1'b1; #1;
        check("R13 taken when branch set", {3'b0, br_taken}, 4'h1);
        jump_req = 1'b0; #1;
        check("R13 no request", {3'b0, br_taken}, 4'h0);
        load_ccr(4'h9);
        jump_req = 1'b1; #1;
        check("R13 branch clear", {3'b0, br_taken}, 4'h0);
        jump_req = 1'b0;

        // R1: reset mid-run clears a loaded register
        load_ccr(4'hF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset after load", ccr_out, 4'h0);

        summary();
    end

endmodule